// File: doc/BRIEF.md
# Linked-list register capture engine

This block is a debug gatherer. A compact program sits in a local SRAM and names the bus registers of interest. On a software trigger the engine walks the program and reads each named register through a bus master that keeps at most one read in flight. The program has two kinds of word. An address word sets a base address. A link word carries two offset/count pairs. Each pair reads a run of consecutive 32-bit registers, and its offset is given as a step from the previous pair under the same base. A zero word ends the program.

In capture mode the values read are written back into the same SRAM. They start at the word index held in the list-length register, which places them directly behind the program. Software reads them out through the SRAM load port. In CRC mode nothing is stored. Each value is folded into a CRC-32, and at the end of a pass the result is compared with the result of the previous pass. A difference, or the absence of an earlier pass since the engine was enabled, raises the CRC-error flag. Software therefore triggers twice after enabling to reach a clean reference.

Top module: `lnk_capture_engine`

## Requirements
- R1: After reset the engine is idle. The status register (index 4) reads 0x10, `bus_req` is 0, `irq` is 0 and the interrupt status (index 6) reads 0.
- R2: A program word with bit 31 set is an address word. Its bits 27:0 multiplied by 16 become the base, and the running word offset returns to 0.
- R3: Any other nonzero word is a link word. The pair in bits 15:0 is served before the pair in bits 31:16. In each pair, bits 7:0 are a word step added to the running offset and bits 14:8 are a count. The pair reads `count` consecutive words, the first at base + 4*offset.
- R4: A pair whose count is 0 issues no bus read and leaves the running offset unchanged. This covers the padding half of a single-pair link word (value 0x0001).
- R5: A zero program word ends the pass. The engine returns to idle, so status bit 4 reads 1, and interrupt status bit 4 is set.
- R6: Writing 1 in bit 0 of the trigger register (index 3) starts a pass only while bit 0 of the enable register (index 0) is 1 and the engine is idle. Otherwise the write has no effect and no bus read occurs.
- R7: Mode register (index 2) bit 0 selects the function: 0 is capture, 1 is CRC. Bit 4 holds a sink selection that is read back only. In capture mode the k-th value read is written to SRAM word LEN+k, where LEN is the list-length register (index 1).
- R8: In CRC mode the first pass after the enable bit rises sets status bit 0 and interrupt status bit 0. A pass whose read data equals that of the previous pass clears status bit 0. A pass with different data sets it again. CRC mode writes nothing to the SRAM.
- R9: Interrupt status bits 0 and 4 are cleared by writing 1 to them. `irq` is high while any interrupt status bit is set whose enable bit (same position in index 5) is set.
- R10: The bus master keeps `bus_req` high with a stable, word-aligned `bus_addr` until `bus_ack`. Each ack completes exactly one read.
- R11: Register port: indices 0 to 6 as named above. Write data is taken when `reg_wr` is high. `reg_rdata` shows the register at `reg_addr` one cycle later. SRAM port reads also return one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ram_we | input | 1 | SRAM load-port write enable |
| ram_addr | input | RAM_AW | SRAM load-port word address |
| ram_wdata | input | 32 | SRAM load-port write data |
| ram_rdata | output | 32 | SRAM load-port read data (one cycle latency) |
| bus_req | output | 1 | Read request toward target registers |
| bus_addr | output | 32 | Byte address of the read |
| bus_ack | input | 1 | Read completion |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the engine with RAM_DEPTH = 64. This keeps the address-port width small, and a six-word program with a seven-word capture region fits with room to spare. The program mixes two bases, a link word holding two active pairs, a single-pair word with padding, and a word whose low pair has a nonzero step but a zero count. A dropped step, a misordered half or an applied padding offset therefore all shift a bus address that the scoreboard predicts. The target model returns data derived from the address and a salt, so the bench can change the salt between CRC passes to force a mismatch or repeat it to force a match.

// File: rtl/lce_pkg.sv
package lce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_DEC   = 3'd2,
    ST_PAIR  = 3'd3,
    ST_READ  = 3'd4,
    ST_DONE  = 3'd5
  } walk_st_t;

  localparam logic [2:0] RI_ENABLE  = 3'd0;
  localparam logic [2:0] RI_LISTLEN = 3'd1;
  localparam logic [2:0] RI_MODE    = 3'd2;
  localparam logic [2:0] RI_TRIG    = 3'd3;
  localparam logic [2:0] RI_STATUS  = 3'd4;
  localparam logic [2:0] RI_IRQEN   = 3'd5;
  localparam logic [2:0] RI_IRQST   = 3'd6;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
endpackage

// File: rtl/lce_dpram.sv
module lce_dpram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_q
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/lce_crc32.sv
module lce_crc32 (
  input  logic [31:0] crc_in,
  input  logic [31:0] data,
  output logic [31:0] crc_out
);
  import lce_pkg::*;
  logic [31:0] c;
  logic        fb;

  always_comb begin
    c  = crc_in;
    fb = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ data[i];
      c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    crc_out = c;
  end
endmodule

// File: rtl/lce_walker.sv
module lce_walker #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          list_en,
  input  logic          crc_mode,
  input  logic [AW-1:0] dst_base,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [31:0]   ram_wdata,
  input  logic [31:0]   ram_q,
  output logic          bus_req,
  output logic [31:0]   bus_addr,
  input  logic          bus_ack,
  input  logic [31:0]   bus_rdata,
  output logic          ready,
  output logic          done,
  output logic          crc_err,
  output logic          crc_fail_pulse
);
  import lce_pkg::*;

  walk_st_t    st_q;
  logic [31:0] base_q, cur_q, link_q, crc_q, ref_q;
  logic [15:0] off_q;
  logic [6:0]  left_q;
  logic        half_q, ref_v_q;
  logic [AW-1:0] ptr_q, wr_q;

  logic [15:0] pair;
  logic [7:0]  step;
  logic [6:0]  cnt;
  logic [15:0] off_nx;
  logic [31:0] crc_nx;
  logic        pair_unused;
  logic        fail_now;

  assign pair        = half_q ? link_q[31:16] : link_q[15:0];
  assign step        = pair[7:0];
  assign cnt         = pair[14:8];
  assign pair_unused = pair[15];
  assign off_nx      = off_q + 16'(step);
  assign fail_now    = !ref_v_q || (crc_q != ref_q);

  lce_crc32 u_crc (.crc_in(crc_q), .data(bus_rdata), .crc_out(crc_nx));

  assign bus_req   = (st_q == ST_READ);
  assign bus_addr  = cur_q;
  assign ready     = (st_q == ST_IDLE);
  assign ram_addr  = (st_q == ST_READ) ? wr_q : ptr_q;
  assign ram_we    = (st_q == ST_READ) && bus_ack && !crc_mode;
  assign ram_wdata = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      base_q <= '0; cur_q <= '0; link_q <= '0;
      crc_q <= CRC_SEED; ref_q <= '0; ref_v_q <= 1'b0;
      off_q <= '0; left_q <= '0; half_q <= 1'b0;
      ptr_q <= '0; wr_q <= '0;
      done <= 1'b0; crc_err <= 1'b0; crc_fail_pulse <= 1'b0;
    end else begin
      done           <= 1'b0;
      crc_fail_pulse <= 1'b0;
      if (!list_en) ref_v_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          ptr_q  <= '0;
          wr_q   <= dst_base;
          base_q <= '0;
          off_q  <= '0;
          crc_q  <= CRC_SEED;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: st_q <= ST_DEC;
        ST_DEC: begin
          ptr_q <= ptr_q + AW'(1);
          if (ram_q == 32'h0) begin
            st_q <= ST_DONE;
          end else if (ram_q[31]) begin
            base_q <= {ram_q[27:0], 4'b0000};
            off_q  <= '0;
            st_q   <= ST_FETCH;
          end else begin
            link_q <= ram_q;
            half_q <= 1'b0;
            st_q   <= ST_PAIR;
          end
        end
        ST_PAIR: begin
          if (cnt == 7'd0) begin
            if (!half_q) half_q <= 1'b1;
            else         st_q   <= ST_FETCH;
          end else begin
            off_q  <= off_nx;
            cur_q  <= base_q + {14'b0, off_nx, 2'b00};
            left_q <= cnt;
            st_q   <= ST_READ;
          end
        end
        ST_READ: if (bus_ack) begin
          cur_q  <= cur_q + 32'd4;
          left_q <= left_q - 7'd1;
          if (crc_mode) crc_q <= crc_nx;
          else          wr_q  <= wr_q + AW'(1);
          if (left_q == 7'd1) begin
            if (!half_q) begin
              half_q <= 1'b1;
              st_q   <= ST_PAIR;
            end else begin
              st_q <= ST_FETCH;
            end
          end
        end
        ST_DONE: begin
          done <= 1'b1;
          if (crc_mode) begin
            crc_err        <= fail_now;
            crc_fail_pulse <= fail_now;
            ref_q          <= crc_q;
            ref_v_q        <= 1'b1;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_capture_engine.sv
module lnk_capture_engine #(
  parameter int RAM_DEPTH = 256,
  parameter int RAM_AW    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ram_we,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic [31:0]       ram_wdata,
  output logic [31:0]       ram_rdata,
  output logic              bus_req,
  output logic [31:0]       bus_addr,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              irq
);
  import lce_pkg::*;

  logic              en_q, func_q, sink_q;
  logic [RAM_AW-1:0] len_q;
  logic [1:0]        ie_q, is_q;
  logic              trig_wr, eng_start, eng_ready, eng_done, eng_err, eng_fail;
  logic [RAM_AW-1:0] eng_addr;
  logic              eng_we;
  logic [31:0]       eng_wdata, eng_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign trig_wr   = reg_wr && (reg_addr == RI_TRIG) && reg_wdata[0];
  assign eng_start = trig_wr && en_q;

  lce_dpram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk(clk),
    .a_we(ram_we), .a_addr(ram_addr), .a_wdata(ram_wdata), .a_q(ram_rdata),
    .b_we(eng_we), .b_addr(eng_addr), .b_wdata(eng_wdata), .b_q(eng_q)
  );

  lce_walker #(.AW(RAM_AW)) u_walk (
    .clk(clk), .rst(rst), .start(eng_start), .list_en(en_q),
    .crc_mode(func_q), .dst_base(len_q),
    .ram_addr(eng_addr), .ram_we(eng_we), .ram_wdata(eng_wdata), .ram_q(eng_q),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .ready(eng_ready), .done(eng_done), .crc_err(eng_err), .crc_fail_pulse(eng_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; func_q <= 1'b0; sink_q <= 1'b0;
      len_q <= '0; ie_q <= '0; is_q <= '0;
      irq <= 1'b0; reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RI_ENABLE:  en_q  <= reg_wdata[0];
          RI_LISTLEN: len_q <= reg_wdata[RAM_AW-1:0];
          RI_MODE:    begin func_q <= reg_wdata[0]; sink_q <= reg_wdata[4]; end
          RI_IRQEN:   ie_q  <= {reg_wdata[4], reg_wdata[0]};
          default: ;
        endcase
      end
      is_q <= (is_q & ~((reg_wr && reg_addr == RI_IRQST) ? {reg_wdata[4], reg_wdata[0]} : 2'b00))
              | {eng_done, eng_fail};
      irq  <= |(is_q & ie_q);
      case (reg_addr)
        RI_ENABLE:  reg_rdata <= {31'b0, en_q};
        RI_LISTLEN: reg_rdata <= {{(32-RAM_AW){1'b0}}, len_q};
        RI_MODE:    reg_rdata <= {27'b0, sink_q, 3'b0, func_q};
        RI_STATUS:  reg_rdata <= {27'b0, eng_ready, 3'b0, eng_err};
        RI_IRQEN:   reg_rdata <= {27'b0, ie_q[1], 3'b0, ie_q[0]};
        RI_IRQST:   reg_rdata <= {27'b0, is_q[1], 3'b0, is_q[0]};
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lce_checker.sv
module lce_checker (
  input logic        clk,
  input logic        rst,
  input logic        bus_req,
  input logic        bus_ack,
  input logic [31:0] bus_addr,
  input logic        ready,
  input logic        list_en,
  input logic        trig_wr,
  input logic        eng_we
);
  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr));

  a_r10_word_aligned: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_addr[1:0] == 2'b00);

  a_r6_trigger_gated: assert property (@(posedge clk) disable iff (rst)
    ready && trig_wr && !list_en |=> ready);

  a_r7_store_on_ack: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> bus_ack && !ready);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ready |-> !bus_req);
endmodule

bind lnk_capture_engine lce_checker u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_addr(bus_addr), .ready(eng_ready), .list_en(en_q),
  .trig_wr(trig_wr), .eng_we(eng_we)
);

// File: tb/lnk_capture_engine_tb.sv
`timescale 1ns/1ps
module lnk_capture_engine_tb;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ram_we = 1'b0;
  logic [AW-1:0] ram_addr = '0;
  logic [31:0] ram_wdata = '0, ram_rdata;
  logic bus_req, bus_ack = 1'b0, irq;
  logic [31:0] bus_addr, bus_rdata = '0;

  int nchk = 0, nfail = 0, nreads = 0;
  logic [31:0] salt = 32'h5A5A_0000;
  logic [31:0] exp_q[$];
  logic [31:0] addrs[7] = '{32'h1000_0008, 32'h1000_000C, 32'h1000_0010,
                            32'h1000_001C, 32'h2000_0044, 32'h2000_0048,
                            32'h2000_0050};

  always #2.5 clk = ~clk;

  lnk_capture_engine #(.RAM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] s);
    return (a * 32'd3) ^ s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // Monitor and target model: pops the expected address for every read.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R6 unexpected read", bus_addr, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(bus_addr == e, "R2/R3/R4 read address", bus_addr, e);
        end
        bus_rdata = model(bus_addr, salt);
        bus_ack   = 1'b1;
        nreads++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wr_ram(input int a, input logic [31:0] d);
    @(negedge clk);
    ram_we = 1'b1; ram_addr = AW'(a); ram_wdata = d;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  task automatic rd_ram(input int a, output logic [31:0] d);
    @(negedge clk);
    ram_addr = AW'(a);
    @(negedge clk);
    d = ram_rdata;
  endtask

  task automatic push_pass();
    foreach (addrs[i]) exp_q.push_back(addrs[i]);
  endtask

  task automatic run_pass(input string req);
    logic [31:0] v;
    bit ok;
    ok = 1'b0;
    push_pass();
    wr_reg(3'd3, 32'h1);
    for (int n = 0; n < 2000; n++) begin
      rd_reg(3'd4, v);
      if (v[4]) begin ok = 1'b1; break; end
    end
    chk(ok, {req, " R5 pass returns to idle"}, v, 32'h10);
    chk(exp_q.size() == 0, {req, " R3 all reads issued"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    logic [31:0] v;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(bus_req == 1'b0, "R1 bus_req idle", bus_req, 0);
    chk(irq == 1'b0, "R1 irq idle", irq, 0);
    rd_reg(3'd4, v); chk(v == 32'h10, "R1 status", v, 32'h10);
    rd_reg(3'd6, v); chk(v == 32'h0, "R1 int status", v, 32'h0);

    // Program
    wr_ram(0, 32'h8100_0000);
    wr_ram(1, 32'h0105_0302);
    wr_ram(2, 32'h8200_0004);
    wr_ram(3, 32'h0001_0201);
    wr_ram(4, 32'h0103_0009);
    wr_ram(5, 32'h0000_0000);
    wr_reg(3'd1, 32'd6);
    wr_reg(3'd2, 32'h10);
    rd_reg(3'd2, v); chk(v == 32'h10, "R11 mode readback", v, 32'h10);
    rd_reg(3'd1, v); chk(v == 32'd6, "R11 list length readback", v, 32'd6);

    // R6: trigger with enable off is ignored
    r0 = nreads;
    wr_reg(3'd3, 32'h1);
    repeat (30) @(negedge clk);
    chk(nreads == r0, "R6 no reads while disabled", nreads, r0);
    rd_reg(3'd4, v); chk(v[4] == 1'b1, "R6 still ready", v, 32'h10);

    // Capture pass
    wr_reg(3'd0, 32'h1);
    wr_reg(3'd5, 32'h11);
    run_pass("capture");
    rd_reg(3'd6, v); chk(v == 32'h10, "R5 done int status", v, 32'h10);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq on done", irq, 1);
    for (int k = 0; k < 7; k++) begin
      rd_ram(6 + k, v);
      chk(v == model(addrs[k], salt), "R7 captured word", v, model(addrs[k], salt));
    end
    rd_ram(5, v); chk(v == 32'h0, "R7 terminator untouched", v, 32'h0);
    wr_reg(3'd6, 32'h10);
    repeat (2) @(negedge clk);
    rd_reg(3'd6, v); chk(v == 32'h0, "R9 write-one clear", v, 32'h0);
    chk(irq == 1'b0, "R9 irq drops", irq, 0);

    // CRC passes
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd0, 32'h1);
    wr_reg(3'd5, 32'h01);
    run_pass("crc1");
    rd_reg(3'd4, v); chk(v == 32'h11, "R8 first pass flags error", v, 32'h11);
    rd_reg(3'd6, v); chk(v == 32'h11, "R8 int status error", v, 32'h11);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 irq on crc error", irq, 1);
    wr_reg(3'd6, 32'h11);

    run_pass("crc2");
    rd_reg(3'd4, v); chk(v == 32'h10, "R8 repeat pass clean", v, 32'h10);
    rd_reg(3'd6, v); chk(v == 32'h10, "R8 no error int", v, 32'h10);

    salt = 32'h0F0F_1234;
    run_pass("crc3");
    rd_reg(3'd4, v); chk(v == 32'h11, "R8 changed data flags error", v, 32'h11);

    run_pass("crc4");
    rd_reg(3'd4, v); chk(v == 32'h10, "R8 new reference clean", v, 32'h10);

    rd_ram(6, v);
    chk(v == model(addrs[0], 32'h5A5A_0000), "R8 no SRAM writes in CRC mode", v,
        model(addrs[0], 32'h5A5A_0000));

    finish_run();
  end
endmodule